// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Sequencer

This block decides, once per machine cycle, whether a pending timer or serial request should interrupt the processor. Its inputs are the interrupt-enable byte, the interrupt-priority byte, four request sources, the current program counter and the stack pointer. It also tracks which priority level is in service.

When it accepts a request, it saves the return address as two bytes through a single byte-wide stack write port. The stack pointer is incremented before each write. The block then loads a fixed vector into the program counter, writes back the final stack pointer and records the accepted level.

Only the two timer-overflow requests are cleared by the block, each with a one-cycle pulse. The serial and third-timer requests stay set until software clears them. A separate clear input stands in for return-from-interrupt and drops the in-service level back to none.

Top module: `irq_sequencer`

## Requirements
- R1: No request is accepted unless `tick_i` is high and bit 7 of `en_reg_i` is set at the same clock edge.
- R2: The high level is scanned before the low level. A high-level request wins over any low-level request pending in the same cycle.
- R3: Level gating uses `act_o` (2'b00 none, 2'b01 low, 2'b10 high).
  - With none in service, both levels are eligible.
  - With low in service, only the high level is eligible.
  - With high in service, nothing is accepted.
- R4: Within a level, sources are taken in a fixed order. Each source needs its own enable bit. The order, with enable bit and vector, is:
  - timer-0 (bit 1, vector 0x0B)
  - timer-1 (bit 3, vector 0x1B)
  - serial, meaning either bit of `ser_req_i` (bit 4, vector 0x23)
  - timer-2 (bit 5, vector 0x2B)
- R5: A source is high level when the `pri_reg_i` bit at the same position as its enable bit is 1, and low level otherwise.
- R6: Let S be the stack pointer captured at acceptance. The sequence is:
  - In the first cycle after acceptance, the block writes the PC low byte to S+1.
  - In the next cycle, it writes the PC high byte to S+2.
  - In the third cycle, it asserts `pc_load_o` with the vector and `sp_wr_o` with S+2.
  - Stack addresses wrap modulo 256.
- R7: `t0_clr_o` pulses only in the first push cycle of a timer-0 acceptance, and `t1_clr_o` likewise for timer-1. Serial and timer-2 acceptances produce no clear pulse.
- R8: `busy_o` is high for exactly the three sequence cycles. The PC and SP used are those present at the acceptance edge. No acceptance happens while busy.
- R9: After reset, `busy_o`, `wr_en_o`, `pc_load_o` and `sp_wr_o` are low and `act_o` is 2'b00.
- R10: The accepted level appears on `act_o` in the cycle after `pc_load_o`. Outside that vector cycle, `lvl_clear_i` returns `act_o` to 2'b00 at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Machine-cycle strobe; acceptance is checked only when high |
| en_reg_i | input | 8 | Interrupt-enable byte (bit 7 global, bits 1/3/4/5 per source) |
| pri_reg_i | input | 8 | Interrupt-priority byte (same bit positions) |
| t0_req_i | input | 1 | Timer-0 overflow request |
| t1_req_i | input | 1 | Timer-1 overflow request |
| ser_req_i | input | 2 | Serial receive/transmit requests |
| t2_req_i | input | 1 | Timer-2 request |
| pc_i | input | PC_W | Current program counter |
| sp_i | input | SP_W | Current stack pointer |
| lvl_clear_i | input | 1 | Return in-service level to none |
| busy_o | output | 1 | Sequence in progress |
| wr_en_o | output | 1 | Stack byte write strobe |
| wr_addr_o | output | SP_W | Stack write address |
| wr_data_o | output | 8 | Stack write data |
| t0_clr_o | output | 1 | Clear pulse for timer-0 request |
| t1_clr_o | output | 1 | Clear pulse for timer-1 request |
| pc_load_o | output | 1 | Load vector into program counter |
| vector_o | output | PC_W | Vector address |
| sp_wr_o | output | 1 | Store final stack pointer |
| sp_o | output | SP_W | Final stack pointer value |
| act_o | output | 2 | In-service level (00 none, 01 low, 10 high) |

## Verification
The bench builds the block with its defaults, PC_W=16 and SP_W=8. With these values both return-address bytes carry live bits, and a stack pointer of 0xFF wraps the two push addresses to 0x00 and 0x01. Random enable, priority and request bytes, combined with random clearing of the in-service level, reach all three gating states and every order conflict. Directed cases cover:
- preempting a low-level handler,
- blocking at the high level,
- the global enable bit alone.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam int NSRC    = 4;
  localparam int GIE_BIT = 7;
  localparam int BYTE_W  = 8;

  typedef enum logic [1:0] {ACT_NONE = 2'b00, ACT_LO = 2'b01, ACT_HI = 2'b10} act_e;
  typedef enum logic [1:0] {ST_IDLE, ST_PUSH_LO, ST_PUSH_HI, ST_VEC} st_e;

  // enable/priority bit position of source k (k = scan order)
  function automatic int unsigned src_bit(input int unsigned k);
    case (k)
      0:       return 1;
      1:       return 3;
      2:       return 4;
      default: return 5;
    endcase
  endfunction

  function automatic logic [7:0] src_vec(input int unsigned k);
    case (k)
      0:       return 8'h0B;
      1:       return 8'h1B;
      2:       return 8'h23;
      default: return 8'h2B;
    endcase
  endfunction
endpackage

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_seq_pkg::*;
(
  input  logic [7:0]      en_i,
  input  logic [7:0]      pri_i,
  input  logic [NSRC-1:0] req_i,
  input  act_e            act_i,
  output logic            hit_o,
  output logic [1:0]      idx_o,
  output logic            lvl_o
);
  logic [NSRC-1:0] cand_hi, cand_lo;
  logic            hi_ok, lo_ok;

  assign hi_ok = (act_i != ACT_HI);
  assign lo_ok = (act_i == ACT_NONE);

  for (genvar k = 0; k < NSRC; k++) begin : g_src
    localparam int unsigned B = src_bit(k);
    assign cand_hi[k] = req_i[k] & en_i[B] &  pri_i[B];
    assign cand_lo[k] = req_i[k] & en_i[B] & ~pri_i[B];
  end

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    lvl_o = 1'b0;
    if (hi_ok) begin
      for (int k = NSRC - 1; k >= 0; k--) begin
        if (cand_hi[k]) begin
          hit_o = 1'b1;
          idx_o = 2'(k);
          lvl_o = 1'b1;
        end
      end
    end
    if (!hit_o && lo_ok) begin
      for (int k = NSRC - 1; k >= 0; k--) begin
        if (cand_lo[k]) begin
          hit_o = 1'b1;
          idx_o = 2'(k);
        end
      end
    end
  end
endmodule

// File: rtl/irq_push_seq.sv
module irq_push_seq
  import irq_seq_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int SP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [1:0]        idx_i,
  input  logic              lvl_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic              clear_i,
  output logic              busy_o,
  output logic              wr_en_o,
  output logic [SP_W-1:0]   wr_addr_o,
  output logic [BYTE_W-1:0] wr_data_o,
  output logic              t0_clr_o,
  output logic              t1_clr_o,
  output logic              pc_load_o,
  output logic [PC_W-1:0]   vector_o,
  output logic              sp_wr_o,
  output logic [SP_W-1:0]   sp_o,
  output act_e              act_o
);
  localparam int RET_W = 2 * BYTE_W;

  st_e             st_q;
  logic [1:0]      idx_q;
  logic            lvl_q;
  logic [PC_W-1:0] pc_q;
  logic [SP_W-1:0] sp_q;
  act_e            act_q;
  logic [RET_W-1:0] ret;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      idx_q <= '0;
      lvl_q <= 1'b0;
      pc_q  <= '0;
      sp_q  <= '0;
      act_q <= ACT_NONE;
    end else begin
      case (st_q)
        ST_IDLE: if (start_i) begin
          st_q  <= ST_PUSH_LO;
          idx_q <= idx_i;
          lvl_q <= lvl_i;
          pc_q  <= pc_i;
          sp_q  <= sp_i;
        end
        ST_PUSH_LO: st_q <= ST_PUSH_HI;
        ST_PUSH_HI: st_q <= ST_VEC;
        default:    st_q <= ST_IDLE;
      endcase
      if (st_q == ST_VEC) act_q <= lvl_q ? ACT_HI : ACT_LO;
      else if (clear_i)   act_q <= ACT_NONE;
    end
  end

  assign ret       = RET_W'(pc_q);
  assign busy_o    = (st_q != ST_IDLE);
  assign wr_en_o   = (st_q == ST_PUSH_LO) || (st_q == ST_PUSH_HI);
  assign wr_addr_o = (st_q == ST_PUSH_LO) ? sp_q + SP_W'(1) : sp_q + SP_W'(2);
  assign wr_data_o = (st_q == ST_PUSH_LO) ? ret[BYTE_W-1:0] : ret[RET_W-1:BYTE_W];
  assign t0_clr_o  = (st_q == ST_PUSH_LO) && (idx_q == 2'd0);
  assign t1_clr_o  = (st_q == ST_PUSH_LO) && (idx_q == 2'd1);
  assign pc_load_o = (st_q == ST_VEC);
  assign vector_o  = PC_W'(src_vec(32'(idx_q)));
  assign sp_wr_o   = (st_q == ST_VEC);
  assign sp_o      = sp_q + SP_W'(2);
  assign act_o     = act_q;
endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer
  import irq_seq_pkg::*;
#(
  parameter int PC_W = 16,
  parameter int SP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [7:0]        en_reg_i,
  input  logic [7:0]        pri_reg_i,
  input  logic              t0_req_i,
  input  logic              t1_req_i,
  input  logic [1:0]        ser_req_i,
  input  logic              t2_req_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic              lvl_clear_i,
  output logic              busy_o,
  output logic              wr_en_o,
  output logic [SP_W-1:0]   wr_addr_o,
  output logic [7:0]        wr_data_o,
  output logic              t0_clr_o,
  output logic              t1_clr_o,
  output logic              pc_load_o,
  output logic [PC_W-1:0]   vector_o,
  output logic              sp_wr_o,
  output logic [SP_W-1:0]   sp_o,
  output logic [1:0]        act_o
);
  logic [NSRC-1:0] req;
  logic            hit, lvl, start;
  logic [1:0]      idx;
  act_e            act;

  assign req   = {t2_req_i, |ser_req_i, t1_req_i, t0_req_i};
  assign start = tick_i & en_reg_i[GIE_BIT] & hit & ~busy_o;
  assign act_o = act;

  irq_arbiter i_arb (
    .en_i  (en_reg_i),
    .pri_i (pri_reg_i),
    .req_i (req),
    .act_i (act),
    .hit_o (hit),
    .idx_o (idx),
    .lvl_o (lvl)
  );

  irq_push_seq #(.PC_W(PC_W), .SP_W(SP_W)) i_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .idx_i     (idx),
    .lvl_i     (lvl),
    .pc_i      (pc_i),
    .sp_i      (sp_i),
    .clear_i   (lvl_clear_i),
    .busy_o    (busy_o),
    .wr_en_o   (wr_en_o),
    .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o),
    .t0_clr_o  (t0_clr_o),
    .t1_clr_o  (t1_clr_o),
    .pc_load_o (pc_load_o),
    .vector_o  (vector_o),
    .sp_wr_o   (sp_wr_o),
    .sp_o      (sp_o),
    .act_o     (act)
  );
endmodule

// File: rtl/irq_sequencer_chk.sv
module irq_sequencer_chk #(
  parameter int SP_W = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            tick_i,
  input logic [7:0]      en_reg_i,
  input logic            busy_o,
  input logic            wr_en_o,
  input logic [SP_W-1:0] wr_addr_o,
  input logic            t0_clr_o,
  input logic            t1_clr_o,
  input logic            pc_load_o,
  input logic            sp_wr_o,
  input logic [SP_W-1:0] sp_o,
  input logic [1:0]      act_o
);
  assert_gie_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(tick_i && en_reg_i[7]));

  assert_hi_blocks_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> $past(act_o) != 2'b10);

  assert_push_order_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |=> wr_en_o && !pc_load_o && (wr_addr_o == $past(wr_addr_o) + SP_W'(1)));

  assert_final_sp_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_wr_o |-> pc_load_o && (sp_o == $past(wr_addr_o)));

  assert_clr_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (t0_clr_o || t1_clr_o) |-> $rose(busy_o) && $onehot0({t0_clr_o, t1_clr_o}));

  assert_write_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_o |-> busy_o);

  assert_vec_end_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |=> !busy_o && act_o != 2'b00);
endmodule

bind irq_sequencer irq_sequencer_chk #(.SP_W(SP_W)) i_chk (.*);

// File: tb/test_irq_sequencer.sv
`timescale 1ns/1ps
module test_irq_sequencer;
  localparam int PC_W = 16;
  localparam int SP_W = 8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic tick = 0, t0 = 0, t1 = 0, t2 = 0, lclr = 0;
  logic [1:0] ser = 0;
  logic [7:0] en = 0, pri = 0;
  logic [PC_W-1:0] pc = 0;
  logic [SP_W-1:0] sp = 0;
  logic busy, wr_en, t0c, t1c, pcl, spw;
  logic [SP_W-1:0] wa, spo;
  logic [7:0] wd;
  logic [PC_W-1:0] vec;
  logic [1:0] act;

  int checks = 0, fails = 0;
  int mact = -1;

  always #2.5 clk = ~clk;

  irq_sequencer #(.PC_W(PC_W), .SP_W(SP_W)) i_irq_sequencer (
    .clk_i(clk), .rst_ni(rst_ni), .tick_i(tick), .en_reg_i(en), .pri_reg_i(pri),
    .t0_req_i(t0), .t1_req_i(t1), .ser_req_i(ser), .t2_req_i(t2), .pc_i(pc), .sp_i(sp),
    .lvl_clear_i(lclr), .busy_o(busy), .wr_en_o(wr_en), .wr_addr_o(wa), .wr_data_o(wd),
    .t0_clr_o(t0c), .t1_clr_o(t1c), .pc_load_o(pcl), .vector_o(vec), .sp_wr_o(spw),
    .sp_o(spo), .act_o(act));

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // returns -1 or level*4+source
  function automatic int pick(input logic [7:0] e, input logic [7:0] p, input logic [3:0] r, input int a);
    int bits [4] = '{1, 3, 4, 5};
    if (!e[7]) return -1;
    for (int l = 1; l >= 0; l--) begin
      if (a < l) begin
        for (int k = 0; k < 4; k++)
          if (r[k] && e[bits[k]] && (p[bits[k]] == l[0])) return l * 4 + k;
      end
    end
    return -1;
  endfunction

  function automatic logic [7:0] vec_of(input int k);
    case (k) 0: return 8'h0B; 1: return 8'h1B; 2: return 8'h23; default: return 8'h2B; endcase
  endfunction

  task automatic clear_lvl();
    @(negedge clk); lclr = 1;
    @(negedge clk); lclr = 0;
    mact = -1;
    chk("R10", 32'(act), 0);
  endtask

  task automatic trial(input logic [7:0] e, input logic [7:0] p, input logic a0, input logic a1,
                       input logic [1:0] s, input logic a2, input logic [PC_W-1:0] pcv,
                       input logic [SP_W-1:0] spv);
    int x, k, l;
    @(negedge clk);
    en = e; pri = p; t0 = a0; t1 = a1; ser = s; t2 = a2; pc = pcv; sp = spv; tick = 1;
    x = pick(e, p, {a2, |s, a1, a0}, mact);
    @(negedge clk);
    tick = 0;
    pc = PC_W'($urandom); sp = SP_W'($urandom);  // must not affect captured values (R8)
    if (x < 0) begin
      chk(e[7] ? "R3" : "R1", 32'(busy), 0);
      chk("R1", 32'(wr_en), 0);
      return;
    end
    k = x % 4; l = x / 4;
    chk("R8", 32'(busy), 1);
    chk("R6", 32'(wr_en), 1);
    chk("R6", 32'(wa), 32'(SP_W'(spv + 1)));
    chk("R6", 32'(wd), 32'(pcv[7:0]));
    chk("R7", 32'(t0c), 32'(k == 0));
    chk("R7", 32'(t1c), 32'(k == 1));
    @(negedge clk);
    chk("R6", 32'(wa), 32'(SP_W'(spv + 2)));
    chk("R6", 32'(wd), 32'(pcv[15:8]));
    chk("R7", 32'({t0c, t1c}), 0);
    @(negedge clk);
    chk("R6", 32'({pcl, spw, wr_en}), 32'b110);
    chk("R4", 32'(vec), 32'(vec_of(k)));
    chk("R6", 32'(spo), 32'(SP_W'(spv + 2)));
    @(negedge clk);
    chk("R8", 32'(busy), 0);
    chk(l == 1 ? "R2" : "R5", 32'(act), l == 1 ? 2 : 1);
    mact = l;
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R9", 32'({busy, wr_en, pcl, spw}), 0);
    chk("R9", 32'(act), 0);
    rst_ni = 1;
    // R1: global enable clear
    trial(8'h7F, 8'h00, 1, 1, 2'b11, 1, 16'h1234, 8'h07);
    // R4: fixed order, all low
    trial(8'hBA, 8'h00, 1, 1, 2'b11, 1, 16'hA55A, 8'h07); clear_lvl();
    trial(8'hBA, 8'h00, 0, 1, 2'b11, 1, 16'h0102, 8'h10); clear_lvl();
    trial(8'hBA, 8'h00, 0, 0, 2'b10, 1, 16'h0304, 8'h20); clear_lvl();
    trial(8'hBA, 8'h00, 0, 0, 2'b00, 1, 16'h0506, 8'h30); clear_lvl();
    // R4: disabled source skipped
    trial(8'hB8, 8'h00, 1, 0, 2'b00, 1, 16'h0708, 8'h40); clear_lvl();
    // R2/R5: timer-2 high beats timer-0 low
    trial(8'hBA, 8'h20, 1, 1, 2'b11, 1, 16'hBEEF, 8'h50);
    // R3: high in service blocks everything
    trial(8'hBA, 8'h3A, 1, 1, 2'b11, 1, 16'h1111, 8'h60);
    clear_lvl();
    // R3: low in service, low blocked, high preempts
    trial(8'hBA, 8'h10, 1, 0, 2'b00, 0, 16'h2222, 8'h70);
    trial(8'hBA, 8'h10, 1, 1, 2'b00, 0, 16'h3333, 8'h70);
    trial(8'hBA, 8'h10, 0, 0, 2'b01, 0, 16'h4444, 8'h72);
    clear_lvl();
    // R6: stack pointer wrap
    trial(8'h82, 8'h00, 1, 0, 2'b00, 0, 16'hC3A5, 8'hFF); clear_lvl();
    trial(8'h82, 8'h00, 1, 0, 2'b00, 0, 16'hC3A5, 8'hFE); clear_lvl();
    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] e;
      e = 8'($urandom);
      if ($urandom_range(3, 0) != 0) e[7] = 1'b1;
      if ($urandom_range(1, 0) == 1) clear_lvl();
      trial(e, 8'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom),
            PC_W'($urandom), SP_W'($urandom));
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule